// File: doc/BRIEF.md
# Slave-Port Arbiter with Idle Parking

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Each master raises a request line. The arbiter answers with a one-hot grant vector, the index of the owning master and a flag that says whether the slave is connected to any master at all. Competing requests are served in rotating order. An owner that has used up a programmable slot of cycles gives way to a waiting master at the next transfer boundary, which the interconnect marks with `xfer_bnd`.

When no master requests, a parking policy sets what the slave does. It can drop the connection, stay with the master it served last, or move to a master named in configuration. A master that finds the slave already parked on it sees its grant in the same cycle it requests. Any other master waits for one clock edge, and that edge is the reconnection penalty that parking is meant to hide.

All settings come from one 32-bit configuration word driven by the surrounding logic. It holds the slot limit, the parking policy and the fixed park index.

Top module: `slv_park_arbiter`

## Requirements
- R1: While `rst` is high and after it is released with no request, `gnt` is all zeros and `connected` is low.
- R2: `gnt` always has at most one bit set. `connected` is high exactly when one bit is set, and that bit is bit `gnt_idx`.
- R3: With policy field `cfg_word[17:16]` at 0 (no parking) or at the reserved value 3, a clock edge at which no request line is high leaves the slave disconnected.
- R4: With policy 1 (park on last owner), a clock edge at which no request is high keeps the slave connected to the same master. That master, raising its request while parked, sees its grant bit already set in that same cycle.
- R5: With policy 2 (park on fixed master), a clock edge at which no request is high connects the slave to the master whose index is in `cfg_word[21:18]`, provided that index is below the master count. Otherwise the slave disconnects.
- R6: A requesting master that the slave is not connected or parked to is not granted in the cycle it raises its request. It is granted from the next clock edge when it is the one chosen.
- R7: An owner that keeps requesting keeps its grant while the slot limit `cfg_word[8:0]` is 0 or no other master requests.
- R8: When the owner stops requesting, or when it is preempted, the next owner is the first requesting master found by scanning upward from the owner's index plus one, wrapping from the highest index to 0.
- R9: With a nonzero slot limit L, an owner that has held the grant for at least L cycles loses it at an edge where another master requests and `xfer_bnd` is high. With `xfer_bnd` low it keeps the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Slot limit [8:0], parking policy [17:16], fixed park index [21:18] |
| req | input | N_MASTERS | One request line per master |
| xfer_bnd | input | 1 | High in a cycle that ends a transfer of the current owner |
| gnt | output | N_MASTERS | Registered one-hot grant |
| gnt_idx | output | $clog2(N_MASTERS) | Index of the granted or last granted master |
| connected | output | 1 | Slave is connected to master `gnt_idx` |

## Verification
All three outputs are registers. A request or configuration change applied in one cycle therefore shows up just after the next rising edge. The one exception is a master that is already parked on, and its grant is visible in the same cycle. The driver applies each stimulus on a falling edge and queues the state expected after the following rising edge. The monitor pops and compares that state two nanoseconds after the rising edge. The same-cycle behaviour of a parked master, and the absence of a grant for a master that is not parked on, are checked directly after the drive and before any edge.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
  localparam int CFG_W    = 32;
  localparam int LIM_LSB  = 0;
  localparam int LIM_W    = 9;
  localparam int MODE_LSB = 16;
  localparam int FIX_LSB  = 18;
  localparam int FIX_W    = 4;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_mode_e;

  typedef struct packed {
    logic [LIM_W-1:0] slot_lim;
    park_mode_e       mode;
    logic [FIX_W-1:0] fix_idx;
  } arb_cfg_t;

  function automatic arb_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    arb_cfg_t c;
    c.slot_lim = w[LIM_LSB +: LIM_W];
    c.mode     = park_mode_e'(w[MODE_LSB +: 2]);
    c.fix_idx  = w[FIX_LSB +: FIX_W];
    return c;
  endfunction
endpackage

// File: rtl/slv_arb_rr_pick.sv
module slv_arb_rr_pick #(
  parameter int N_MASTERS = 16,
  localparam int IDX_W = $clog2(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] cand,
  input  logic [IDX_W-1:0]     base,
  output logic                 found,
  output logic [IDX_W-1:0]     pick
);
  // Scan from base+N down to base+1 so the closest candidate after base wins last.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N_MASTERS; i >= 1; i--) begin
      int j;
      j = (int'(base) + i) % N_MASTERS;
      if (cand[j]) begin
        found = 1'b1;
        pick  = j[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/slv_arb_slot_timer.sv
module slv_arb_slot_timer #(
  parameter int LIM_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);
  logic [LIM_W-1:0] cnt_q;

  // Ownership cycles; the first granted cycle counts as 1, saturating.
  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (restart)                cnt_q <= LIM_W'(1);
    else if (active && cnt_q != '1)  cnt_q <= cnt_q + LIM_W'(1);
  end

  assign expired = (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/slv_park_arbiter.sv
module slv_park_arbiter #(
  parameter int N_MASTERS = 16,
  localparam int IDX_W = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          cfg_word,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 xfer_bnd,
  output logic [N_MASTERS-1:0] gnt,
  output logic [IDX_W-1:0]     gnt_idx,
  output logic                 connected
);
  import slv_arb_pkg::*;

  arb_cfg_t             cfg;
  logic                 conn_q, conn_n;
  logic [IDX_W-1:0]     own_q, own_n;
  logic [N_MASTERS-1:0] gnt_q, own_oh, cand;
  logic                 owner_busy, found, expired, restart;
  logic [IDX_W-1:0]     pick;
  logic [IDX_W-1:0]     fix_trunc;
  logic                 fix_ok;

  assign cfg        = unpack_cfg(cfg_word);
  assign own_oh     = N_MASTERS'(1) << own_q;
  assign owner_busy = conn_q && req[own_q];
  assign cand       = owner_busy ? (req & ~own_oh) : req;
  assign fix_trunc  = IDX_W'(cfg.fix_idx);
  assign fix_ok     = (32'(cfg.fix_idx) < N_MASTERS);

  slv_arb_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .cand  (cand),
    .base  (own_q),
    .found (found),
    .pick  (pick)
  );

  slv_arb_slot_timer #(.LIM_W(LIM_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .active  (conn_q),
    .limit   (cfg.slot_lim),
    .expired (expired)
  );

  always_comb begin
    conn_n = conn_q;
    own_n  = own_q;
    if (owner_busy) begin
      if (expired && found && xfer_bnd) own_n = pick;
    end else if (found) begin
      conn_n = 1'b1;
      own_n  = pick;
    end else begin
      unique case (cfg.mode)
        PARK_LAST: ;
        PARK_FIXED: begin
          conn_n = fix_ok;
          if (fix_ok) own_n = fix_trunc;
        end
        default: conn_n = 1'b0;
      endcase
    end
  end

  assign restart = conn_n && (!conn_q || own_n != own_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      own_q  <= '0;
      gnt_q  <= '0;
    end else begin
      conn_q <= conn_n;
      own_q  <= own_n;
      gnt_q  <= conn_n ? (N_MASTERS'(1) << own_n) : '0;
    end
  end

  assign gnt       = gnt_q;
  assign gnt_idx   = own_q;
  assign connected = conn_q;
endmodule

// File: rtl/slv_park_arbiter_chk.sv
module slv_park_arbiter_chk #(
  parameter int N_MASTERS = 16,
  localparam int IDX_W = $clog2(N_MASTERS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [31:0]          cfg_word,
  input logic [N_MASTERS-1:0] req,
  input logic [N_MASTERS-1:0] gnt,
  input logic [IDX_W-1:0]     gnt_idx,
  input logic                 connected
);
  logic [1:0] mode;
  logic [3:0] fix;
  assign mode = cfg_word[17:16];
  assign fix  = cfg_word[21:18];

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && (connected == (gnt != '0)) && (!connected || gnt[gnt_idx]));

  a_r3_unparked_drop: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd0 || mode == 2'd3) && req == '0) |=> !connected);

  a_r4_last_park_holds: assert property (@(posedge clk) disable iff (rst)
    (connected && mode == 2'd1 && req == '0) |=> (connected && $stable(gnt_idx)));

  a_r5_fixed_park_target: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && req == '0 && 32'(fix) < N_MASTERS)
      |=> (connected && 32'(gnt_idx) == 32'($past(fix))));

  a_r7_owner_keeps: assert property (@(posedge clk) disable iff (rst)
    (connected && req[gnt_idx] && cfg_word[8:0] == '0) |=> (connected && $stable(gnt_idx)));
endmodule

bind slv_park_arbiter slv_park_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk(clk), .rst(rst), .cfg_word(cfg_word), .req(req),
  .gnt(gnt), .gnt_idx(gnt_idx), .connected(connected)
);

// File: tb/tb_slv_park_arbiter.sv
module tb_slv_park_arbiter;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   cfg_word = '0;
  logic [N-1:0]  req = '0;
  logic          xfer_bnd = 1'b0;
  logic [N-1:0]  gnt;
  logic [3:0]    gnt_idx;
  logic          connected;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit         conn;
    logic [3:0] idx;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  slv_park_arbiter #(.N_MASTERS(N)) dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .req(req), .xfer_bnd(xfer_bnd),
    .gnt(gnt), .gnt_idx(gnt_idx), .connected(connected)
  );

  function automatic logic [31:0] mk_cfg(input int lim, input int mode, input int fix);
    logic [31:0] w;
    w = '0;
    w[8:0]   = 9'(lim);
    w[17:16] = 2'(mode);
    w[21:18] = 4'(fix);
    return w;
  endfunction

  task automatic cmp(input bit c, input logic [3:0] i, input string tag);
    logic [N-1:0] eg;
    eg = c ? (N'(1) << i) : '0;
    total++;
    if (connected !== c || gnt !== eg || (c && gnt_idx !== i)) begin
      bad++;
      $display("FAIL %s: conn=%0b gnt=%h idx=%0d expected conn=%0b gnt=%h idx=%0d",
               tag, connected, gnt, gnt_idx, c, eg, i);
    end
  endtask

  // Driver: apply on the falling edge, queue the state due after the next rising edge.
  task automatic step(input logic [31:0] cw, input logic [N-1:0] r, input bit b,
                      input bit ec, input int ei, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_word = cw;
    req      = r;
    xfer_bnd = b;
    e.conn = ec;
    e.idx  = 4'(ei);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Monitor
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.conn, e.idx, e.tag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, c_last, c_fix, c_rsv, c_lim;
    c0     = mk_cfg(0, 0, 0);
    c_last = mk_cfg(0, 1, 0);
    c_fix  = mk_cfg(0, 2, 9);
    c_rsv  = mk_cfg(0, 3, 9);
    c_lim  = mk_cfg(3, 0, 0);

    repeat (3) @(posedge clk);
    #2 cmp(1'b0, 4'd0, "R1 in reset");
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #2 cmp(1'b0, 4'd0, "R1 after reset idle");

    // No parking: one-edge latency, drop when idle
    step(c0, N'(1) << 3, 1'b1, 1'b1, 3, "R6 first grant after edge");
    #1 begin total++; if (gnt !== '0) begin bad++; $display("FAIL R6: gnt=%h expected %h", gnt, N'(0)); end end
    step(c0, N'(1) << 3, 1'b1, 1'b1, 3, "R7 owner keeps");
    step(c0, '0, 1'b1, 1'b0, 0, "R3 idle drop");
    step(c0, N'(1) << 3, 1'b1, 1'b1, 3, "R6 reconnect penalty");
    #1 begin total++; if (gnt !== '0) begin bad++; $display("FAIL R6: gnt=%h expected %h", gnt, N'(0)); end end

    // Park on last
    step(c_last, '0, 1'b1, 1'b1, 3, "R4 park last");
    step(c_last, N'(1) << 3, 1'b1, 1'b1, 3, "R4 parked owner resumes");
    #1 begin total++; if (gnt !== (N'(1) << 3)) begin bad++; $display("FAIL R4: gnt=%h expected %h", gnt, N'(1) << 3); end end
    step(c_last, N'(1) << 5, 1'b1, 1'b1, 5, "R8 handover to 5");
    #1 begin total++; if (gnt[5] !== 1'b0) begin bad++; $display("FAIL R6: gnt=%h expected bit5 clear", gnt); end end

    // Park on fixed 9
    step(c_fix, '0, 1'b1, 1'b1, 9, "R5 park fixed 9");
    step(c_fix, N'(1) << 9, 1'b1, 1'b1, 9, "R5 fixed master resumes");
    #1 begin total++; if (gnt !== (N'(1) << 9)) begin bad++; $display("FAIL R5: gnt=%h expected %h", gnt, N'(1) << 9); end end
    step(c_fix, '0, 1'b1, 1'b1, 9, "R5 stays on fixed");
    step(c_rsv, '0, 1'b1, 1'b0, 0, "R3 reserved policy drops");

    // Round robin from owner+1
    step(c0, (N'(1) << 2) | (N'(1) << 7) | (N'(1) << 12), 1'b1, 1'b1, 12, "R8 scan from 10");
    step(c0, (N'(1) << 2) | (N'(1) << 7) | (N'(1) << 12), 1'b1, 1'b1, 12, "R7 no limit keeps 12");
    step(c0, (N'(1) << 2) | (N'(1) << 7), 1'b1, 1'b1, 2, "R8 wrap to 2");
    step(c0, N'(1) << 7, 1'b1, 1'b1, 7, "R8 next is 7");
    step(c0, '0, 1'b1, 1'b0, 0, "R3 drop before limit test");

    // Slot limit 3
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b1, 1'b1, 1, "R8 scan from 8 to 1");
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b1, 1'b1, 1, "R9 held cycle 2");
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b1, 1'b1, 1, "R9 held cycle 3");
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b1, 1'b1, 7, "R9 preempt to 7");
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b0, 1'b1, 7, "R9 hold no boundary a");
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b0, 1'b1, 7, "R9 hold no boundary b");
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b0, 1'b1, 7, "R9 expired no boundary");
    step(c_lim, (N'(1) << 1) | (N'(1) << 7), 1'b1, 1'b1, 1, "R9 preempt at boundary");
    for (int k = 0; k < 6; k++)
      step(c_lim, N'(1) << 1, 1'b1, 1'b1, 1, "R7 lone owner past limit");

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #2 cmp(1'b0, 4'd0, "R1 reset while owned");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule